// File: doc/BRIEF.md
# Centre-Aligned Pulse-Width Level Encoder

This block turns a multi-level sample code into a single-bit pulse train whose high time is proportional to the code. Each sample period is a frame of fast ticks. A triangular up/down count runs through the frame, and the output goes high when the count passes a threshold set by the code. The pulse therefore always sits symmetrically about the middle of the frame. The edge rate of the output is set by the frame carrier, not by how fast the code changes. One instance drives each element chain of a converter path.

With the default 33 levels the frame is 66 ticks long, and code c produces 2c high ticks. A code with its strobe is captured at any time. It only reaches the comparator at the frame boundary, so a frame never contains two pulse widths.

Top module: `dspwm_encoder`

## Requirements
- R1: A synchronous active-high reset forces `pwm_out` low and clears the pending code and the active code to 0. The frame restarts at phase 0 with the first clock edge after reset is released.
- R2: The phase of the output observed after the k-th rising edge following reset release is k mod 66. The internal triangle takes values 0,1,…,32 in phases 0–32 and 32,31,…,0 in phases 33–65.
- R3: An active code c (0–32) produces exactly 2c high ticks in its frame.
- R4: For code c the output is high in exactly the phases 33−c through 32+c. The first and last high phases sum to 65, which centres the pulse between phases 32 and 33.
- R5: Code 0 holds `pwm_out` low for the whole frame.
- R6: Code 32 holds `pwm_out` high in every phase except 0 and 65.
- R7: `code_in` is 6 bits wide; a strobed value above 32 is treated as 32.
- R8: A code strobed in the middle of a frame becomes active in the next frame. Values on `code_in` without `code_vld` have no effect.
- R9: When several strobes fall in one frame, the last one wins. A strobe in the same cycle as phase 65 is applied to the very next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, 66 ticks per sample |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 6 | Level code, 0–32, saturating above |
| code_vld | input | 1 | Strobe capturing `code_in` |
| pwm_out | output | 1 | Registered centre-aligned pulse |

## Verification
Every code from 0 to 40 is applied for a full frame, each strobed mid-frame. For every tick the output is compared with the phase window computed from the code, which separates a wrong threshold, a wrong triangle turnaround and an off-centre pulse. Out-of-range codes show whether saturation works. Frames with unstrobed code changes, several strobes, and a strobe on the last tick show whether capture and hand-over happen at the boundary and whether the last strobe wins. A reset in the middle of a frame shows that the phase and the codes restart.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
  localparam int unsigned DEF_LEVELS = 33;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } tri_dir_e;
endpackage

// File: rtl/dspwm_tri_counter.sv
module dspwm_tri_counter
  import dspwm_pkg::*;
#(
  parameter int unsigned MAX = 32,
  parameter int unsigned CW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output tri_dir_e      dir,
  output logic          frame_end
);
  localparam logic [CW-1:0] MAX_V = CW'(MAX);

  // Each end value is held for one extra tick while the direction flips,
  // so a frame is 2*MAX+2 ticks long.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dir <= DIR_UP;
    end else if (dir == DIR_UP) begin
      if (cnt == MAX_V) dir <= DIR_DOWN;
      else              cnt <= cnt + 1'b1;
    end else begin
      if (cnt == '0) dir <= DIR_UP;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign frame_end = (dir == DIR_DOWN) && (cnt == '0);
endmodule

// File: rtl/dspwm_code_latch.sv
module dspwm_code_latch #(
  parameter int unsigned MAX = 32,
  parameter int unsigned CW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] code_in,
  input  logic          code_vld,
  input  logic          frame_end,
  output logic [CW-1:0] active
);
  localparam logic [CW-1:0] MAX_V = CW'(MAX);

  logic [CW-1:0] sat_code;
  logic [CW-1:0] pending;

  assign sat_code = (code_in > MAX_V) ? MAX_V : code_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      active  <= '0;
    end else begin
      if (code_vld) pending <= sat_code;
      if (frame_end) active <= code_vld ? sat_code : pending;
    end
  end
endmodule

// File: rtl/dspwm_compare.sv
module dspwm_compare #(
  parameter int unsigned MAX = 32,
  parameter int unsigned CW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] active,
  output logic          pwm_out
);
  localparam logic [CW-1:0] MAX_V = CW'(MAX);

  logic [CW-1:0] threshold;
  assign threshold = MAX_V - active;

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= (cnt > threshold);
  end
endmodule

// File: rtl/dspwm_encoder.sv
module dspwm_encoder
  import dspwm_pkg::*;
#(
  parameter int unsigned LEVELS = DEF_LEVELS,
  parameter int unsigned CW     = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] code_in,
  input  logic          code_vld,
  output logic          pwm_out
);
  localparam int unsigned MAX = LEVELS - 1;

  logic [CW-1:0] tri_cnt;
  tri_dir_e      tri_dir;
  logic          tri_down;
  logic          frame_end;
  logic [CW-1:0] active_code;

  assign tri_down = (tri_dir == DIR_DOWN);

  dspwm_tri_counter #(.MAX(MAX), .CW(CW)) u_tri (
    .clk       (clk),
    .rst       (rst),
    .cnt       (tri_cnt),
    .dir       (tri_dir),
    .frame_end (frame_end)
  );

  dspwm_code_latch #(.MAX(MAX), .CW(CW)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .code_in   (code_in),
    .code_vld  (code_vld),
    .frame_end (frame_end),
    .active    (active_code)
  );

  dspwm_compare #(.MAX(MAX), .CW(CW)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .cnt     (tri_cnt),
    .active  (active_code),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/dspwm_encoder_chk.sv
module dspwm_encoder_chk #(
  parameter int unsigned MAX = 32,
  parameter int unsigned CW  = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic          dir_down,
  input logic [CW-1:0] active,
  input logic          pwm_out
);
  localparam logic [CW-1:0] MAX_V = CW'(MAX);

  logic at_boundary;
  assign at_boundary = dir_down && (cnt == '0);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= MAX_V);

  assert_climb_R2: assert property (@(posedge clk) disable iff (rst)
    (!dir_down && cnt != MAX_V) |=> (!dir_down && cnt == $past(cnt) + 1'b1));

  assert_active_sat_R7: assert property (@(posedge clk) disable iff (rst)
    active <= MAX_V);

  assert_active_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !at_boundary |=> $stable(active));

  assert_zero_low_R5: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |=> !pwm_out);

  assert_full_high_R6: assert property (@(posedge clk) disable iff (rst)
    (active == MAX_V && cnt != '0) |=> pwm_out);
endmodule

bind dspwm_encoder dspwm_encoder_chk #(.MAX(MAX), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt      (tri_cnt),
  .dir_down (tri_down),
  .active   (active_code),
  .pwm_out  (pwm_out)
);

// File: tb/dspwm_encoder_test.sv
`timescale 1ns/1ps
module dspwm_encoder_test;
  localparam int FRAME = 66;
  localparam int MAXC  = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] code_in = '0;
  logic       code_vld = 1'b0;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int exp_act = 0;
  int exp_pend = 0;
  int hi_cnt = 0;
  int first_hi = -1;
  int last_hi = -1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dspwm_encoder uut (
    .clk(clk), .rst(rst), .code_in(code_in), .code_vld(code_vld), .pwm_out(pwm_out)
  );

  function automatic int sat(input int c);
    return (c > MAXC) ? MAXC : c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp, k);
    end
  endtask

  task automatic do_reset(input int cycles);
    rst = 1'b1;
    code_vld = 1'b0;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    check(pwm_out == 1'b0, "R1 output low in reset", int'(pwm_out), 0);
    rst = 1'b0;
    k = 0; exp_act = 0; exp_pend = 0;
    hi_cnt = 0; first_hi = -1; last_hi = -1;
  endtask

  // One tick: drive inputs, let edge k happen, check output for phase k mod 66.
  task automatic tick(input bit vld, input int code);
    int ph, tv, e;
    code_in = 6'(code);
    code_vld = vld;
    @(posedge clk);
    @(negedge clk);
    ph = k % FRAME;
    tv = (ph <= MAXC) ? ph : (FRAME - 1 - ph);
    e = (tv > MAXC - exp_act) ? 1 : 0;
    check(int'(pwm_out) == e, "R4 phase window", int'(pwm_out), e);
    if (pwm_out) begin
      hi_cnt++;
      if (first_hi < 0) first_hi = ph;
      last_hi = ph;
    end
    if (ph == FRAME - 1) begin
      check(hi_cnt == 2 * exp_act, "R3 high ticks per frame", hi_cnt, 2 * exp_act);
      if (exp_act == 0)
        check(hi_cnt == 0, "R5 code zero all low", hi_cnt, 0);
      else
        check(first_hi + last_hi == FRAME - 1, "R4 centred pulse", first_hi + last_hi, FRAME - 1);
      if (exp_act == MAXC)
        check(first_hi == 1 && last_hi == FRAME - 2, "R6 full code edges", first_hi * 100 + last_hi, 100 + FRAME - 2);
      exp_act = vld ? sat(code) : exp_pend;
      hi_cnt = 0; first_hi = -1; last_hi = -1;
    end
    if (vld) exp_pend = sat(code);
    k++;
  endtask

  task automatic run_frame(input int sphase, input int code);
    for (int p = 0; p < FRAME; p++) tick(p == sphase, code);
  endtask

  initial begin
    do_reset(3);
    // R2/R3/R4 sweep; codes above 32 exercise R7 saturation.
    for (int c = 0; c <= 40; c++) run_frame(20, c);
    run_frame(FRAME, 0);
    // R8: code_in changes without strobe have no effect.
    run_frame(10, 9);
    for (int p = 0; p < FRAME; p++) tick(1'b0, (p * 7) % 33);
    for (int p = 0; p < FRAME; p++) tick(1'b0, 31);
    // R9: several strobes in one frame, last (on phase 65) wins.
    for (int p = 0; p < FRAME; p++)
      tick(p == 3 || p == 40 || p == FRAME - 1, (p == 3) ? 7 : (p == 40) ? 12 : 20);
    run_frame(FRAME - 1, 3);
    run_frame(FRAME, 0);
    run_frame(0, 45);   // R7: saturated value taken
    run_frame(FRAME, 0);
    // R1: reset in mid frame restarts phase and clears codes.
    for (int p = 0; p < 30; p++) tick(p == 5, 16);
    do_reset(2);
    run_frame(FRAME, 0);
    run_frame(50, 11);
    run_frame(FRAME, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule